// File: doc/BRIEF.md
# Automatic Offset Calibration Sequencer

This block runs a one-shot digital offset calibration each time a register-controlled reset mode is released. While calibration runs, it takes signed ADC error samples from a valid/ready stream. For every sample it moves an offset-cancel code one LSB towards the value that drives the sample to zero. The window lasts a fixed number of clock cycles, 40000 by default, which is 2 ms at 20 MHz. When the window closes, the cancel code is frozen.

The block adds a black-level clamp code from a register to the frozen cancel code and drives the sum to the DAC code output. Before it is added, the clamp value is forced into the range 14 to 76 LSB.

The ADC stream has one back-pressure rule: `s_ready` is high only while calibration is busy. A sample is consumed on a clock edge where both `s_valid` and `s_ready` are high. Samples offered at any other time stay with the source and have no effect. If reset mode is raised during calibration, the window is aborted and the cancel code is cleared. A fresh, full window starts when reset mode is released again.

Top module: `offset_cal_seq`

## Requirements
- R1: After `rst_n` is released, `busy` and `s_ready` are low, the cancel code is 0, and `dac_code` equals the limited clamp code.
- R2: `busy` rises on the first clock edge at which `reset_mode` is sampled low after having been sampled high. While `reset_mode` is high, `busy` stays low.
- R3: Once started, `busy` stays high for exactly CAL_CYCLES consecutive clock cycles (default 40000) and then falls by itself.
- R4: On each consumed sample, the cancel code steps by 1 LSB. It goes down by one for a positive sample, up by one for a negative sample, and stays put for a zero sample. The sample is signed two's complement. The code saturates at -128 and +127 (8-bit signed).
- R5: `dac_code` is the signed 10-bit sum of the cancel code and the limited clamp code. It follows both inputs combinationally.
- R6: The 7-bit unsigned `clamp_code` is limited before the addition: values below 14 become 14, values above 76 become 76, and values from 14 to 76 pass unchanged.
- R7: Once calibration has ended, the cancel code holds its value. Samples offered with `s_valid` high do not change `dac_code`.
- R8: If `reset_mode` is sampled high during calibration, `busy` falls on that edge and the cancel code becomes 0. Releasing `reset_mode` starts a new full CAL_CYCLES window.
- R9: `s_ready` equals `busy`. A sample is consumed only on an edge where both `s_valid` and `s_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| reset_mode | input | 1 | Register reset-mode bit; releasing it starts calibration |
| s_valid | input | 1 | ADC sample valid |
| s_ready | output | 1 | ADC sample ready, high while calibrating |
| s_data | input | 8 | Signed ADC error sample |
| clamp_code | input | 7 | Black-level clamp register value, unsigned |
| dac_code | output | 10 | Signed DAC code: cancel code plus limited clamp |
| busy | output | 1 | Calibration in progress |

## Verification
Some properties are checked on every cycle. The cancel code moves by at most one LSB per cycle. It stays stable whenever the block is neither calibrating nor in reset mode. Reset mode always drops `busy` on the following cycle. A falling `busy` without reset mode happens only at the last count. The clamp part of `dac_code` stays between 14 and 76. Other behaviour can only be shown by the bench scenarios against its reference model. These are the exact window length, the start on the edge after release, and the abort and full restart. They also include saturation under a constant positive error, the ignoring of samples after the window, and the clamp limits at 13, 14, 76 and 77.

// File: rtl/offset_cal_pkg.sv
package offset_cal_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // direction of one correction step from the sign and zero flags of a sample
  function automatic step_e step_of(input logic neg, input logic zero);
    if (zero)     return STEP_HOLD;
    else if (neg) return STEP_UP;
    else          return STEP_DOWN;
  endfunction
endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CAL_CYCLES = 40000,
  parameter int CNT_W      = $clog2(CAL_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_mode,
  output logic busy
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

  logic             pend_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (reset_mode) begin
      pend_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;

  // R8
  mode_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |=> !busy_q);

  // R3
  end_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !reset_mode && cnt_q != LAST) |=> busy_q);

  // R2
  idle_without_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !pend_q && !reset_mode) |=> !busy_q);
endmodule

// File: rtl/cancel_acc.sv
module cancel_acc
  import offset_cal_pkg::*;
#(
  parameter int SW = 8,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 take,
  input  logic signed [SW-1:0] sample,
  output logic signed [CW-1:0] cancel
);
  localparam logic signed [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] MINV = {1'b1, {(CW-1){1'b0}}};

  logic signed [CW-1:0] acc_q;
  step_e                dir;

  always_comb dir = step_of(sample[SW-1], sample == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (take) begin
      case (dir)
        STEP_UP:   if (acc_q != MAXV) acc_q <= acc_q + 1'b1;
        STEP_DOWN: if (acc_q != MINV) acc_q <= acc_q - 1'b1;
        default:   acc_q <= acc_q;
      endcase
    end
  end

  assign cancel = acc_q;

  // R4
  one_lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((acc_q - $past(acc_q)) inside {-1, 0, 1}));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !clear) |=> $stable(acc_q));
endmodule

// File: rtl/clamp_limit.sv
module clamp_limit #(
  parameter int CLW = 7,
  parameter int LO  = 14,
  parameter int HI  = 76
) (
  input  logic [CLW-1:0] raw,
  output logic [CLW-1:0] lim
);
  localparam logic [CLW-1:0] LO_C = CLW'(LO);
  localparam logic [CLW-1:0] HI_C = CLW'(HI);

  always_comb begin
    if (raw < LO_C)      lim = LO_C;
    else if (raw > HI_C) lim = HI_C;
    else                 lim = raw;
  end
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq #(
  parameter int CAL_CYCLES = 40000,
  parameter int SW         = 8,
  parameter int CW         = 8,
  parameter int CLW        = 7,
  parameter int CLAMP_LO   = 14,
  parameter int CLAMP_HI   = 76,
  parameter int DAC_W      = ((CW > CLW + 1) ? CW : CLW + 1) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reset_mode,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic signed [SW-1:0]    s_data,
  input  logic        [CLW-1:0]   clamp_code,
  output logic signed [DAC_W-1:0] dac_code,
  output logic                    busy
);
  logic                    busy_w;
  logic signed [CW-1:0]    cancel;
  logic        [CLW-1:0]   clamp_lim;
  logic signed [DAC_W-1:0] cancel_ext;
  logic signed [DAC_W-1:0] clamp_ext;
  logic signed [DAC_W-1:0] clamp_part;

  cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_mode (reset_mode),
    .busy       (busy_w)
  );

  cancel_acc #(.SW(SW), .CW(CW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (reset_mode),
    .take   (s_valid && busy_w),
    .sample (s_data),
    .cancel (cancel)
  );

  clamp_limit #(.CLW(CLW), .LO(CLAMP_LO), .HI(CLAMP_HI)) u_clamp (
    .raw (clamp_code),
    .lim (clamp_lim)
  );

  assign cancel_ext = DAC_W'(cancel);
  assign clamp_ext  = DAC_W'({1'b0, clamp_lim});
  assign dac_code   = cancel_ext + clamp_ext;
  assign s_ready    = busy_w;
  assign busy       = busy_w;
  assign clamp_part = dac_code - cancel_ext;

  // R6
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_part >= DAC_W'(CLAMP_LO)) && (clamp_part <= DAC_W'(CLAMP_HI)));
endmodule

// File: tb/sim_offset_cal_seq.sv
module sim_offset_cal_seq;
  localparam int CLK_P = 10;
  localparam int CAL   = 40000;
  localparam int WD    = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reset_mode = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic signed [7:0] s_data = '0;
  logic [6:0]        clamp_code = 7'd40;
  logic signed [9:0] dac_code;
  logic              busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_cancel = 0;
  bit m_pend = 0;
  bit m_busy = 0;
  int m_cnt = 0;
  int busy_run = 0;

  always #(CLK_P/2) clk = ~clk;

  offset_cal_seq u0 (
    .clk(clk), .rst_n(rst_n), .reset_mode(reset_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .clamp_code(clamp_code), .dac_code(dac_code), .busy(busy)
  );

  function automatic int lim_of(input int c);
    if (c < 14) return 14;
    if (c > 76) return 76;
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(busy == m_busy, "R3 busy", int'(busy), int'(m_busy));
    chk(s_ready == m_busy, "R9 s_ready", int'(s_ready), int'(m_busy));
    chk(int'(dac_code) == m_cancel + lim_of(int'(clamp_code)), "R4 R5 dac_code",
        int'(dac_code), m_cancel + lim_of(int'(clamp_code)));
  endtask

  task automatic tick(input bit v, input int d, input bit rm);
    bit acc;
    s_valid = v;
    s_data = d[7:0];
    reset_mode = rm;
    @(posedge clk);
    acc = v && m_busy;
    if (rm) begin
      m_pend = 1; m_busy = 0; m_cnt = 0; m_cancel = 0;
    end else begin
      if (acc) begin
        if (d > 0 && m_cancel > -128) m_cancel--;
        else if (d < 0 && m_cancel < 127) m_cancel++;
      end
      if (m_pend) begin
        m_pend = 0; m_busy = 1; m_cnt = 0;
      end else if (m_busy) begin
        if (m_cnt == CAL - 1) begin m_busy = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
    @(negedge clk);
    compare_all();
    if (busy) busy_run++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, WD);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    int d;
    int held;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(s_ready == 1'b0, "R1 s_ready", int'(s_ready), 0);
    chk(int'(dac_code) == 40, "R1 dac_code", int'(dac_code), 40);

    // R2: busy held low during reset mode, rises on first low edge
    repeat (4) tick(1, 3, 1);
    chk(busy == 1'b0, "R2 low in mode", int'(busy), 0);
    tick(1, 3, 0);
    chk(busy == 1'b1, "R2 start", int'(busy), 1);

    // R8: abort mid-window
    for (int i = 0; i < 150; i++) tick(1, 5, 0);
    tick(1, 5, 1);
    chk(busy == 1'b0, "R8 abort busy", int'(busy), 0);
    chk(int'(dac_code) == 40, "R8 abort clear", int'(dac_code), 40);
    tick(0, 0, 1);

    // full window with random samples
    busy_run = 0;
    for (int i = 0; i < CAL + 4; i++) begin
      d = int'($urandom_range(0, 14)) - 6;
      tick($urandom_range(0, 3) != 0, d, 0);
    end
    // R3 R8 full restart length
    chk(busy_run == CAL, "R3 R8 window length", busy_run, CAL);

    // R7: samples after window ignored
    held = int'(dac_code);
    for (int i = 0; i < 50; i++) tick(1, 9, 0);
    chk(int'(dac_code) == held, "R7 held", int'(dac_code), held);
    chk(s_ready == 1'b0, "R7 R9 not ready", int'(s_ready), 0);

    // R4 saturation under constant positive error
    tick(0, 0, 1);
    busy_run = 0;
    for (int i = 0; i < CAL + 2; i++) tick(1, 4, 0);
    chk(int'(dac_code) == -128 + 40, "R4 saturate low", int'(dac_code), -88);
    chk(busy_run == CAL, "R3 second window", busy_run, CAL);

    // R6 clamp limits
    clamp_code = 7'd0;   #1; chk(int'(dac_code) == -128 + 14, "R6 clamp 0", int'(dac_code), -114);
    clamp_code = 7'd13;  #1; chk(int'(dac_code) == -128 + 14, "R6 clamp 13", int'(dac_code), -114);
    clamp_code = 7'd14;  #1; chk(int'(dac_code) == -128 + 14, "R6 clamp 14", int'(dac_code), -114);
    clamp_code = 7'd76;  #1; chk(int'(dac_code) == -128 + 76, "R6 clamp 76", int'(dac_code), -52);
    clamp_code = 7'd77;  #1; chk(int'(dac_code) == -128 + 76, "R6 clamp 77", int'(dac_code), -52);
    clamp_code = 7'd127; #1; chk(int'(dac_code) == -128 + 76, "R6 clamp 127", int'(dac_code), -52);
    for (int i = 0; i < 20; i++) begin
      clamp_code = 7'($urandom_range(0, 127));
      #1;
      chk(int'(dac_code) == -128 + lim_of(int'(clamp_code)), "R5 R6 random clamp",
          int'(dac_code), -128 + lim_of(int'(clamp_code)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule